// File: doc/BRIEF.md
# Preemptive Prioritized Interrupt Controller

The controller gathers 114 peripheral interrupt lines and 8 request bits that software sets. Together these form 122 sources, and each source has a programmable 4-bit priority. Every cycle it picks the pending source with the highest priority. It offers that source to the processor as a single request with a 9-bit vector equal to the source index, but only while the chosen priority is strictly above the current priority.

When the processor acknowledges, the current priority is saved on a 16-entry LIFO and replaced by the priority of the accepted source. Higher-priority work can therefore nest inside an interrupt service routine. An end-of-interrupt pulse pops the LIFO and restores the level that was interrupted.

Software may also write the current priority directly. This raises a task's level while it holds a shared resource, which is the priority ceiling protocol.

A small register port gives software access to the state. It can read and write every source priority, set and clear the software request bits, and read or write the current priority. A sticky error bit records overflow and underflow of the LIFO.

Top module: `prio_intc`

## Requirements
- R1: Sources 0..113 are the peripheral lines `irq_in[i]`. Sources 114..121 are software bits 0..7. The vector presented on `cpu_vec` is the index of the chosen source.
- R2: Register addresses 0..121 hold the 4-bit priority of the source with that index, in bits [3:0], and read back the written value. After reset all priorities, the software bits and the current priority are 0, the error bit is clear and `cpu_req` is low.
- R3: `cpu_req` is high only while the best pending priority is strictly greater than the current priority. An equal or lower priority never raises it.
- R4: Among pending sources of equal top priority, the lowest source index is presented.
- R5: A source whose priority is 0 never causes a request.
- R6: A peripheral line that qualifies is reflected on `cpu_req` and `cpu_vec` exactly after the third rising clock edge that follows its assertion. It is not visible after the first or second edge.
- R7: `cpu_ack` while `cpu_req` is high pushes the current priority and loads the priority of the presented source. `cpu_ack` while `cpu_req` is low has no effect.
- R8: `cpu_eoi` alone pops the LIFO and restores the popped value as the current priority.
- R9: Address 0x80 reads as {error in bit 7, 0, current priority in bits [3:0]}. A write there sets the current priority. If an acknowledge or end-of-interrupt happens in the same cycle, that stack operation takes precedence and the write is dropped.
- R10: A write to address 0x81 sets the software bits given by the 1s of the data. A write to 0x82 clears them. A read of 0x81 returns the bits. Acknowledge clears neither software bits nor peripheral requests.
- R11: The LIFO holds 16 entries. A push when it is full, or a pop when it is empty, sets the sticky error bit and leaves the current priority and the LIFO unchanged.
- R12: `cpu_ack` with `cpu_req` high and `cpu_eoi` in the same cycle loads the acknowledged priority and leaves the LIFO depth unchanged. If the LIFO is empty, this is an underflow as in R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 114 | Peripheral request lines, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_vec | output | 9 | Vector (source index) of the presented request |
| cpu_ack | input | 1 | Processor accepts the presented request |
| cpu_eoi | input | 1 | Processor ends the current service routine |

## Verification
An acknowledge and an end-of-interrupt can land in the same cycle. This happens when one service routine finishes just as a higher-priority request is taken. The bench provokes it by holding a nested request pending and pulsing both inputs together. It then judges the result by reading the current priority, which must equal the new source's priority. A following single end-of-interrupt must restore the level saved before the first nesting, which shows the depth did not change. The same cycle collision is also driven between an acknowledge and a software write of the current priority, where the acknowledged level must win.

// File: rtl/prio_intc_pkg.sv
// Package: shared defaults, register addresses and stack operation codes
// for the prioritized interrupt controller.
package prio_intc_pkg;
    localparam int NUM_HW_DEF    = 114;
    localparam int NUM_SW_DEF    = 8;
    localparam int PRIO_W_DEF    = 4;
    localparam int VEC_W_DEF     = 9;
    localparam int DEPTH_DEF     = 16;
    localparam int ADDR_W_DEF    = 8;
    localparam int DATA_W_DEF    = 8;

    // Register map outside the per-source priority range.
    localparam int ADDR_CUR_PRIO = 'h80;
    localparam int ADDR_SW_SET   = 'h81;
    localparam int ADDR_SW_CLR   = 'h82;

    // Operation applied to the priority stack in one cycle.
    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;
endpackage

// File: rtl/intc_src_regs.sv
// Source register file.
// Holds the first pipeline stage of the peripheral lines, the software
// request bits and one priority register per source. Produces the pending
// mask, where a source only counts when its priority is nonzero.
// Assumes the source count stays below the first control address and
// that the software bit count is at most the data width.
module intc_src_regs #(
    parameter int NUM_HW   = 114,
    parameter int NUM_SW   = 8,
    parameter int PRIO_W   = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_SET = 'h81,
    parameter int ADDR_CLR = 'h82,
    localparam int NUM_SRC = NUM_HW + NUM_SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] irq_in,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PRIO_W-1:0] prio_o [NUM_SRC],
    output logic [NUM_SW-1:0] sw_o,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_HW-1:0]  hw_q;
    logic [NUM_SW-1:0]  sw_q;
    logic [NUM_SRC-1:0] raw;

    // Stage one: capture the peripheral lines.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= '0;
        else        hw_q <= irq_in;
    end

    // Software request bits: set and clear by mask writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_q <= '0;
        else if (wr && addr == ADDR_W'(ADDR_SET))
            sw_q <= sw_q | wdata[NUM_SW-1:0];
        else if (wr && addr == ADDR_W'(ADDR_CLR))
            sw_q <= sw_q & ~wdata[NUM_SW-1:0];
    end

    assign raw  = {sw_q, hw_q};
    assign sw_o = sw_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [PRIO_W-1:0] prio_q;
        // Per-source priority register written at its own address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q <= '0;
            else if (wr && addr == ADDR_W'(i))
                prio_q <= wdata[PRIO_W-1:0];
        end
        assign prio_o[i] = prio_q;
        assign pend_o[i] = raw[i] && (prio_q != '0);
    end
endmodule

// File: rtl/intc_arbiter.sv
// Priority arbiter.
// Finds the pending source with the highest priority and breaks ties
// toward the lowest index. The result is registered, which forms
// pipeline stage two. Assumes pending sources all have nonzero priority.
module intc_arbiter #(
    parameter int NUM_SRC = 122,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [PRIO_W-1:0]  prio [NUM_SRC],
    output logic               win_valid,
    output logic [PRIO_W-1:0]  win_prio,
    output logic [VEC_W-1:0]   win_vec
);
    logic [PRIO_W-1:0] best_p;
    logic [VEC_W-1:0]  best_i;

    // Scan from high index to low so that equal priorities settle on the lowest index.
    always_comb begin
        best_p = '0;
        best_i = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && prio[i] >= best_p) begin
                best_p = prio[i];
                best_i = VEC_W'(i);
            end
        end
    end

    // Stage two: register the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_prio  <= '0;
            win_vec   <= '0;
        end else begin
            win_valid <= |pend;
            win_prio  <= best_p;
            win_vec   <= best_i;
        end
    end
endmodule

// File: rtl/intc_prio_stack.sv
// Current priority register with a LIFO of preempted priorities.
// A push saves the current level and loads a new one. A pop restores the
// saved level. A swap loads a new level and keeps the depth. Overflow and
// underflow set a sticky error and change nothing else. A software write
// applies only in a cycle without a stack operation.
module intc_prio_stack
    import prio_intc_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 16,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  stk_op_e            op,
    input  logic [PRIO_W-1:0]  load_prio,
    input  logic               sw_wr,
    input  logic [PRIO_W-1:0]  sw_prio,
    output logic [PRIO_W-1:0]  cur_prio,
    output logic [DEPTH_W-1:0] depth,
    output logic               err
);
    logic [PRIO_W-1:0] mem [DEPTH];
    logic              full, empty;
    logic [IDX_W-1:0]  top_idx;

    assign full    = (depth == DEPTH_W'(DEPTH));
    assign empty   = (depth == '0);
    assign top_idx = IDX_W'(depth - DEPTH_W'(1));

    // Stack storage: written on an accepted push only.
    always_ff @(posedge clk) begin
        if (op == STK_PUSH && !full)
            mem[depth[IDX_W-1:0]] <= cur_prio;
    end

    // Current level, depth and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_prio <= '0;
            depth    <= '0;
            err      <= 1'b0;
        end else begin
            case (op)
                STK_PUSH: begin
                    if (full) err <= 1'b1;
                    else begin
                        depth    <= depth + DEPTH_W'(1);
                        cur_prio <= load_prio;
                    end
                end
                STK_POP: begin
                    if (empty) err <= 1'b1;
                    else begin
                        depth    <= depth - DEPTH_W'(1);
                        cur_prio <= mem[top_idx];
                    end
                end
                STK_SWAP: begin
                    if (empty) err <= 1'b1;
                    else       cur_prio <= load_prio;
                end
                default: begin
                    if (sw_wr) cur_prio <= sw_prio;
                end
            endcase
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Top of the preemptive prioritized interrupt controller.
// Pipeline: line capture, arbitration register, output register, so a
// line shows on the request after three edges. The request compares the
// output register with the live current priority, so it drops in the
// same cycle an acknowledge raises the level.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_HW      = NUM_HW_DEF,
    parameter int NUM_SW      = NUM_SW_DEF,
    parameter int PRIO_W      = PRIO_W_DEF,
    parameter int VEC_W       = VEC_W_DEF,
    parameter int STACK_DEPTH = DEPTH_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    localparam int NUM_SRC    = NUM_HW + NUM_SW,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] irq_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cpu_req,
    output logic [VEC_W-1:0]  cpu_vec,
    input  logic              cpu_ack,
    input  logic              cpu_eoi
);
    logic [PRIO_W-1:0]  src_prio [NUM_SRC];
    logic [NUM_SW-1:0]  sw_bits;
    logic [NUM_SRC-1:0] pend;
    logic               win_valid;
    logic [PRIO_W-1:0]  win_prio;
    logic [VEC_W-1:0]   win_vec;
    logic               out_valid;
    logic [PRIO_W-1:0]  out_prio;
    logic [VEC_W-1:0]   out_vec;
    logic [PRIO_W-1:0]  cur_prio;
    logic [DEPTH_W-1:0] stk_depth;
    logic               stk_err;
    logic               ack_take;
    logic               cur_wr;
    stk_op_e            stk_op;

    intc_src_regs #(
        .NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_SET(ADDR_SW_SET), .ADDR_CLR(ADDR_SW_CLR)
    ) u_src (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .prio_o(src_prio), .sw_o(sw_bits), .pend_o(pend)
    );

    intc_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .prio(src_prio),
        .win_valid(win_valid), .win_prio(win_prio), .win_vec(win_vec)
    );

    // Stage three: output register holding the offered source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prio  <= '0;
            out_vec   <= '0;
        end else begin
            out_valid <= win_valid;
            out_prio  <= win_prio;
            out_vec   <= win_vec;
        end
    end

    assign cpu_req = out_valid && (out_prio > cur_prio);
    assign cpu_vec = out_vec;

    // Decode the stack operation from the processor handshake.
    always_comb begin
        ack_take = cpu_ack && cpu_req;
        if (ack_take && cpu_eoi) stk_op = STK_SWAP;
        else if (ack_take)       stk_op = STK_PUSH;
        else if (cpu_eoi)        stk_op = STK_POP;
        else                     stk_op = STK_NONE;
    end

    assign cur_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CUR_PRIO));

    intc_prio_stack #(
        .PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)
    ) u_stk (
        .clk(clk), .rst_n(rst_n), .op(stk_op), .load_prio(out_prio),
        .sw_wr(cur_wr), .sw_prio(reg_wdata[PRIO_W-1:0]),
        .cur_prio(cur_prio), .depth(stk_depth), .err(stk_err)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CUR_PRIO)) begin
            reg_rdata[DATA_W-1]   = stk_err;
            reg_rdata[PRIO_W-1:0] = cur_prio;
        end else if (reg_addr == ADDR_W'(ADDR_SW_SET)) begin
            reg_rdata[NUM_SW-1:0] = sw_bits;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (reg_addr == ADDR_W'(i)) reg_rdata[PRIO_W-1:0] = src_prio[i];
            end
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Checker for the interrupt controller, bound into the top module.
// Observes the processor handshake, the offered priority and the stack state.
module prio_intc_chk #(
    parameter int PRIO_W  = 4,
    parameter int DEPTH   = 16,
    parameter int DEPTH_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_ack,
    input logic               cpu_eoi,
    input logic [PRIO_W-1:0]  out_prio,
    input logic [PRIO_W-1:0]  cur_prio,
    input logic [DEPTH_W-1:0] depth,
    input logic               err
);
    // R3
    req_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cur_prio != {PRIO_W{1'b1}}));

    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack && !cpu_eoi && depth < DEPTH_W'(DEPTH)) |=>
        (cur_prio == $past(out_prio) && depth == $past(depth) + DEPTH_W'(1)));

    // R8
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_eoi && !(cpu_req && cpu_ack) && depth != '0) |=>
        (depth == $past(depth) - DEPTH_W'(1)));

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_W'(DEPTH));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R11
    overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack && !cpu_eoi && depth == DEPTH_W'(DEPTH)) |=>
        (err && cur_prio == $past(cur_prio) && depth == $past(depth)));

    // R12
    tail_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack && cpu_eoi && depth != '0) |=>
        (depth == $past(depth) && cur_prio == $past(out_prio)));
endmodule

bind prio_intc prio_intc_chk #(
    .PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
    .cpu_eoi(cpu_eoi), .out_prio(out_prio), .cur_prio(cur_prio),
    .depth(stk_depth), .err(stk_err)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    localparam int NHW = 114;
    localparam int NSW = 8;
    localparam int NS  = NHW + NSW;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NHW-1:0] irq_in;
    logic           reg_wr;
    logic [7:0]     reg_addr, reg_wdata, reg_rdata;
    logic           cpu_req, cpu_ack, cpu_eoi;
    logic [8:0]     cpu_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [3:0] m_prio [NS];
    logic [7:0] m_sw;
    logic [3:0] m_cur;

    always #4 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        cpu_ack = 0; cpu_eoi = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NS; i++) m_prio[i] = 0;
        m_sw = 0; m_cur = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 0;
        if (a < NS) m_prio[a] = 4'(d);
        else if (a == 'h80) m_cur = 4'(d);
        else if (a == 'h81) m_sw = m_sw | 8'(d);
        else if (a == 'h82) m_sw = m_sw & ~8'(d);
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 8'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input bit ack, input bit eoi);
        @(negedge clk);
        cpu_ack = ack; cpu_eoi = eoi;
        @(negedge clk);
        cpu_ack = 0; cpu_eoi = 0;
    endtask

    // Expected request and vector from the model state.
    task automatic check_req(input string tag);
        int bi, bp;
        bit ex;
        bi = 0; bp = 0;
        for (int i = NS - 1; i >= 0; i--) begin
            bit raw;
            raw = (i < NHW) ? irq_in[i] : m_sw[i - NHW];
            if (raw && m_prio[i] != 0 && int'(m_prio[i]) >= bp) begin
                bp = int'(m_prio[i]); bi = i;
            end
        end
        ex = (bp > int'(m_cur));
        check({tag, " req"}, int'(cpu_req), int'(ex));
        if (ex) check({tag, " vec"}, int'(cpu_vec), bi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int d;
        int pushed [16];
        void'($urandom(32'h5eed1234));
        do_reset();

        // R2 reset state and priority readback
        @(negedge clk);
        check("R2 reset req", int'(cpu_req), 0);
        rd('h80, d); check("R2 reset cur", d, 0);
        rd('h81, d); check("R2 reset sw", d, 0);
        rd(5, d);    check("R2 reset prio", d, 0);
        wr(5, 9);    rd(5, d);   check("R2 prio readback", d, 9);
        wr(121, 15); rd(121, d); check("R2 prio readback top", d, 15);
        wr(5, 0); wr(121, 0);

        // R6 three-edge latency, R1 vector
        wr(7, 3); settle();
        irq_in[7] = 1'b1;
        @(negedge clk); check("R6 edge1", int'(cpu_req), 0);
        @(negedge clk); check("R6 edge2", int'(cpu_req), 0);
        @(negedge clk); check("R6 edge3", int'(cpu_req), 1);
        check("R1 vec", int'(cpu_vec), 7);

        // R3 equal priority does not preempt, lower cur allows
        wr('h80, 3); @(negedge clk); check_req("R3 equal");
        check("R3 equal blocked", int'(cpu_req), 0);
        wr('h80, 2); @(negedge clk); check_req("R3 above");
        check("R3 above raised", int'(cpu_req), 1);
        wr('h80, 0);

        // R5 priority zero never requests
        irq_in[7] = 0; irq_in[50] = 1; settle();
        check("R5 zero prio", int'(cpu_req), 0);

        // R4 ties resolve to lowest index
        wr(30, 12); wr(40, 12); wr(60, 12);
        irq_in[30] = 1; irq_in[40] = 1; irq_in[60] = 1; settle();
        check("R4 tie", int'(cpu_vec), 30); check_req("R4 tie");
        irq_in[30] = 0; settle();
        check("R4 tie next", int'(cpu_vec), 40);

        // R10 software bit acts like a source
        wr(116, 13); wr('h81, 'h04); settle();
        check("R10 sw vec", int'(cpu_vec), 116);
        rd('h81, d); check("R10 sw read", d, 4);
        wr('h82, 'h04); settle();
        check("R10 sw clear", int'(cpu_vec), 40);

        // R7 acknowledge pushes and loads
        pulse(1, 0); m_cur = 12;
        rd('h80, d); check("R7 cur after ack", d, 12);
        check_req("R7 after ack");
        pulse(1, 0);
        rd('h80, d); check("R7 ack ignored", d, 12);

        // Nest a higher software source, then unwind (R8, R10)
        wr(116, 15); wr('h81, 'h04); settle();
        check("R10 nest vec", int'(cpu_vec), 116);
        pulse(1, 0);
        rd('h80, d); check("R7 nested cur", d, 15);
        rd('h81, d); check("R10 sw kept on ack", d, 4);
        pulse(0, 1);
        rd('h80, d); check("R8 pop to 12", d, 12);
        settle(); check("R10 still pending", int'(cpu_vec), 116);
        check("R10 still req", int'(cpu_req), 1);
        pulse(0, 1);
        rd('h80, d); check("R8 pop to 0", d, 0);
        pulse(0, 1);
        rd('h80, d); check("R11 underflow err", d, 'h80);

        // R12 acknowledge and end-of-interrupt together
        do_reset();
        wr(10, 4); irq_in[10] = 1; settle();
        pulse(1, 0);
        wr(20, 9); irq_in[20] = 1; settle();
        check("R12 pending vec", int'(cpu_vec), 20);
        pulse(1, 1);
        rd('h80, d); check("R12 swap cur", d, 9);
        pulse(0, 1);
        rd('h80, d); check("R12 depth kept", d, 0);
        pulse(0, 1);
        rd('h80, d); check("R12 then empty", d, 'h80);

        // R9 acknowledge beats a same-cycle write of the current level
        do_reset();
        wr(10, 4); irq_in[10] = 1; settle();
        @(negedge clk);
        cpu_ack = 1; reg_wr = 1; reg_addr = 8'h80; reg_wdata = 8'd2;
        @(negedge clk);
        cpu_ack = 0; reg_wr = 0;
        rd('h80, d); check("R9 ack wins", d, 4);
        pulse(0, 1);
        rd('h80, d); check("R9 restored", d, 0);

        // R11 overflow after sixteen pushes, then sixteen pops
        do_reset();
        wr(3, 15); irq_in[3] = 1; settle();
        for (int k = 0; k < 16; k++) begin
            pushed[k] = k % 15;
            wr('h80, pushed[k]);
            pulse(1, 0);
        end
        wr('h80, 2);
        pulse(1, 0);
        rd('h80, d); check("R11 overflow err cur kept", d, 'h82);
        for (int k = 15; k >= 0; k--) begin
            pulse(0, 1);
            rd('h80, d); check("R8 R11 pop order", d, 'h80 | pushed[k]);
        end

        // R3 R4 R5 random configurations
        do_reset();
        for (int i = 0; i < NS; i++) wr(i, int'($urandom_range(0, 15)));
        for (int it = 0; it < 150; it++) begin
            for (int j = 0; j < 6; j++) wr(int'($urandom_range(0, NS - 1)), int'($urandom_range(0, 15)));
            for (int i = 0; i < NHW; i++) irq_in[i] = ($urandom_range(0, 7) == 0);
            wr('h82, 'hff);
            wr('h81, int'($urandom_range(0, 255)) & int'($urandom_range(0, 255)));
            wr('h80, int'($urandom_range(0, 15)));
            settle();
            check_req("R3 R4 R5 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule